// File: doc/BRIEF.md
# Shared-Bus Accumulator Computer

An 8-bit accumulator machine built around one internal bus. Instruction words and data words both sit in a single 16-word memory and reach the registers over that bus. Five bus sources are possible: the program counter, the memory read port, the low half of the instruction register, the accumulator and the adder/subtractor. A 12-signal control word chooses which source drives the bus in each step and which registers capture it.

A ring sequencer gives every instruction the same six steps. The first three steps fetch the instruction. The last three execute it.

The memory is filled through a dedicated write port while the block is held in reset. After reset is released, the machine runs the program from address 0. It stops on a halt instruction. The accumulator value reaches the outside only through the output register.

Top module: `acc_cpu`

## Requirements
- R1: The memory has 16 words of 8 bits. When `load_en_i` is high, the word `load_data_i` is written at address `load_addr_i` on a rising clock edge. Every one of the 16 addresses, 0 through 15, can be written and read back as an operand.
- R2: While `rst_ni` is low, the block is forced to its reset state: `out_o` = 00h, `halted_o` = 0, the program counter at 0, and the sequencer on its first step.
- R3: Every instruction takes exactly six clock cycles, steps 1 to 6.
  - Step 1 moves the program counter into the address register.
  - Step 2 increments the program counter.
  - Step 3 loads the addressed word into the instruction register.
  - The output of instruction k (counting from 0 after reset) changes at clock edge 6k+4, for an output instruction, or at edge 6k+6, for an accumulator write.
- R4: In an instruction word, bits [7:4] are the opcode and bits [3:0] are an address. Opcode 0000 loads the word at that address into the accumulator.
- R5: Opcode 0001 copies the addressed word into register B and then writes A+B into A, modulo 256.
- R6: Opcode 0010 copies the addressed word into register B and then writes A−B into A, modulo 256.
- R7: Opcode 0011 copies A into the output register on step 4. The output register holds its value in every other cycle.
- R8: Opcode 1111 sets `halted_o` on step 4. From then until reset, the sequencer and the output register stay frozen.
- R9: Opcodes other than 0000, 0001, 0010, 0011 and 1111 change neither A nor the output register.
- R10: At most one source drives the shared bus in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous clear |
| load_en_i | input | 1 | Memory preload write enable |
| load_addr_i | input | 4 | Memory preload address |
| load_data_i | input | 8 | Memory preload data |
| out_o | output | 8 | Output register |
| halted_o | output | 1 | Set once a halt instruction has executed |

## Verification
The assertions assume that memory is written only while the block is held in reset, so that the program and data are stable during execution. The bench keeps to this: it drives the preload port only while `rst_ni` is low and releases reset one edge after the last write.

The stimulus is several short programs. Together they cover addition and subtraction that wrap around 256, an undefined opcode, an operand at address 15, and a halt as the very first instruction. The bench compares `out_o` and `halted_o` with a step-counting model on every cycle.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int OP_W    = 4;
  localparam int N_STEPS = 6;

  typedef enum logic [OP_W-1:0] {
    OP_LDA = 4'h0,
    OP_ADD = 4'h1,
    OP_SUB = 4'h2,
    OP_OUT = 4'h3,
    OP_HLT = 4'hF
  } op_e;

  // one bit per control line
  typedef struct packed {
    logic cp;  // pc count
    logic ep;  // pc -> bus
    logic lm;  // load mar
    logic ce;  // mem -> bus
    logic li;  // load ir
    logic ei;  // ir addr -> bus
    logic la;  // load a
    logic ea;  // a -> bus
    logic su;  // subtract select
    logic eu;  // alu -> bus
    logic lb;  // load b
    logic lo;  // load out
  } ctrl_t;
endpackage

// File: rtl/acc_ring.sv
module acc_ring #(
  parameter int N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  output logic [N-1:0] step_o
);
  logic [N-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= N'(1);
    else if (!hold_i) q <= {q[N-2:0], q[N-1]};
  end

  assign step_o = q;
endmodule

// File: rtl/acc_ctrl_dec.sv
module acc_ctrl_dec
  import acc_cpu_pkg::*;
(
  input  logic [N_STEPS-1:0] step_i,
  input  logic [OP_W-1:0]    op_i,
  input  logic               run_i,
  output ctrl_t              ctrl_o,
  output logic               halt_set_o
);
  always_comb begin
    ctrl_o     = '0;
    halt_set_o = 1'b0;
    if (run_i) begin
      if (step_i[0]) begin
        ctrl_o.ep = 1'b1;
        ctrl_o.lm = 1'b1;
      end
      if (step_i[1]) ctrl_o.cp = 1'b1;
      if (step_i[2]) begin
        ctrl_o.ce = 1'b1;
        ctrl_o.li = 1'b1;
      end
      if (step_i[3]) begin
        case (op_i)
          OP_LDA, OP_ADD, OP_SUB: begin
            ctrl_o.ei = 1'b1;
            ctrl_o.lm = 1'b1;
          end
          OP_OUT: begin
            ctrl_o.ea = 1'b1;
            ctrl_o.lo = 1'b1;
          end
          OP_HLT:  halt_set_o = 1'b1;
          default: ;
        endcase
      end
      if (step_i[4]) begin
        case (op_i)
          OP_LDA: begin
            ctrl_o.ce = 1'b1;
            ctrl_o.la = 1'b1;
          end
          OP_ADD, OP_SUB: begin
            ctrl_o.ce = 1'b1;
            ctrl_o.lb = 1'b1;
          end
          default: ;
        endcase
      end
      if (step_i[5]) begin
        case (op_i)
          OP_ADD: begin
            ctrl_o.eu = 1'b1;
            ctrl_o.la = 1'b1;
          end
          OP_SUB: begin
            ctrl_o.su = 1'b1;
            ctrl_o.eu = 1'b1;
            ctrl_o.la = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/acc_mem.sv
module acc_mem #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  output logic [DW-1:0] y_o
);
  assign y_o = sub_i ? (a_i - b_i) : (a_i + b_i);
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_en_i,
  input  logic [ADDR_W-1:0]        load_addr_i,
  input  logic [OP_W+ADDR_W-1:0]   load_data_i,
  output logic [OP_W+ADDR_W-1:0]   out_o,
  output logic                     halted_o
);
  localparam int DW    = OP_W + ADDR_W;
  localparam int N_SRC = 5;

  logic [ADDR_W-1:0]  pc_q, mar_q;
  logic [DW-1:0]      ir_q, a_q, b_q, out_q;
  logic [DW-1:0]      bus, mem_rd, alu_y;
  logic               halted_q, halt_set;
  logic [N_STEPS-1:0] ring_q;
  ctrl_t              ctrl;
  logic [N_SRC-1:0]   drv;
  logic [DW-1:0]      src   [N_SRC];
  logic [DW-1:0]      gated [N_SRC];

  acc_ring #(.N(N_STEPS)) u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (halted_q),
    .step_o (ring_q)
  );

  acc_ctrl_dec u_dec (
    .step_i     (ring_q),
    .op_i       (ir_q[DW-1:ADDR_W]),
    .run_i      (!halted_q),
    .ctrl_o     (ctrl),
    .halt_set_o (halt_set)
  );

  acc_mem #(.AW(ADDR_W), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (load_en_i),
    .waddr_i (load_addr_i),
    .wdata_i (load_data_i),
    .raddr_i (mar_q),
    .rdata_o (mem_rd)
  );

  acc_alu #(.DW(DW)) u_alu (
    .a_i   (a_q),
    .b_i   (b_q),
    .sub_i (ctrl.su),
    .y_o   (alu_y)
  );

  // shared bus: masked sources OR'd together, one enable at a time
  assign drv    = {ctrl.eu, ctrl.ea, ctrl.ei, ctrl.ce, ctrl.ep};
  assign src[0] = {{(DW-ADDR_W){1'b0}}, pc_q};
  assign src[1] = mem_rd;
  assign src[2] = {{(DW-ADDR_W){1'b0}}, ir_q[ADDR_W-1:0]};
  assign src[3] = a_q;
  assign src[4] = alu_y;

  for (genvar g = 0; g < N_SRC; g++) begin : g_drv
    assign gated[g] = drv[g] ? src[g] : '0;
  end

  always_comb begin
    bus = '0;
    for (int k = 0; k < N_SRC; k++) bus = bus | gated[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      mar_q    <= '0;
      ir_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
      out_q    <= '0;
      halted_q <= 1'b0;
    end else begin
      if (ctrl.cp) pc_q  <= pc_q + 1'b1;
      if (ctrl.lm) mar_q <= bus[ADDR_W-1:0];
      if (ctrl.li) ir_q  <= bus;
      if (ctrl.la) a_q   <= bus;
      if (ctrl.lb) b_q   <= bus;
      if (ctrl.lo) out_q <= bus;
      if (halt_set) halted_q <= 1'b1;
    end
  end

  assign out_o    = out_q;
  assign halted_o = halted_q;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int ADDR_W = 4,
  parameter int DW     = 8,
  parameter int N_SRC  = 5,
  parameter int NS     = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  drv_i,
  input logic [NS-1:0]     ring_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic              lo_i,
  input logic [DW-1:0]     out_i,
  input logic              halted_i
);
  // R10
  one_driver_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(drv_i) <= 1);

  // R3
  ring_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ring_i) == 1);

  // R3
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ring_i[1] && !halted_i) |=> (pc_i == $past(pc_i) + 1'b1));

  // R3
  pc_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ring_i[1] |=> $stable(pc_i));

  // R7
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lo_i |=> $stable(out_i));

  // R8
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> (halted_i && $stable(ring_i) && $stable(out_i)));
endmodule

bind acc_cpu acc_cpu_chk #(
  .ADDR_W (ADDR_W),
  .DW     (DW),
  .N_SRC  (N_SRC),
  .NS     (acc_cpu_pkg::N_STEPS)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .drv_i    (drv),
  .ring_i   (ring_q),
  .pc_i     (pc_q),
  .lo_i     (ctrl.lo),
  .out_i    (out_q),
  .halted_i (halted_q)
);

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_en_i = 1'b0;
  logic [3:0] load_addr_i = '0;
  logic [7:0] load_data_i = '0;
  logic [7:0] out_o;
  logic       halted_o;

  int n_vec  = 0;
  int n_fail = 0;

  // behavioural model state
  int prog [16];
  int m_pc, m_ph, m_ir, m_a, m_out;
  bit m_halt;

  always #5 clk_i = ~clk_i;

  acc_cpu u0 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_en_i   (load_en_i),
    .load_addr_i (load_addr_i),
    .load_data_i (load_data_i),
    .out_o       (out_o),
    .halted_o    (halted_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 16; i++) prog[i] = 0;
  endtask

  // R1: preload all 16 words under reset
  task automatic start_prog();
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < 16; i++) begin
      load_en_i   = 1'b1;
      load_addr_i = 4'(i);
      load_data_i = 8'(prog[i]);
      @(negedge clk_i);
    end
    load_en_i = 1'b0;
    chk("R2 reset out", out_o, 0);
    chk("R2 reset halted", halted_o, 0);
    m_pc = 0; m_ph = 0; m_ir = 0; m_a = 0; m_out = 0; m_halt = 0;
    rst_ni = 1'b1;
  endtask

  task automatic model_edge();
    int op, ad;
    if (m_halt) return;
    op = (m_ir >> 4) & 15;
    ad = m_ir & 15;
    case (m_ph)
      0: begin m_ir = prog[m_pc]; m_pc = (m_pc + 1) % 16; end
      3: begin
        if (op == 3)  m_out = m_a;
        if (op == 15) m_halt = 1;
      end
      5: begin
        if (op == 0) m_a = prog[ad];
        if (op == 1) m_a = (m_a + prog[ad]) & 255;
        if (op == 2) m_a = (m_a - prog[ad]) & 255;
      end
      default: ;
    endcase
    m_ph = (m_ph + 1) % 6;
  endtask

  task automatic step(int n);
    for (int c = 0; c < n; c++) begin
      @(posedge clk_i);
      model_edge();
      @(negedge clk_i);
      chk("R3/R10 out", out_o, m_out);
      chk("R3/R8 halted", halted_o, int'(m_halt));
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    // program 1: reference sum
    clear_prog();
    prog[0] = 8'h09; prog[1] = 8'h1A; prog[2] = 8'h1B; prog[3] = 8'h2C;
    prog[4] = 8'h30; prog[5] = 8'hF0;
    prog[9] = 8'h01; prog[10] = 8'h04; prog[11] = 8'h02; prog[12] = 8'h03;
    start_prog();
    step(60);
    chk("R5 R6 sum result", out_o, 8'h04);
    chk("R8 halted after run", halted_o, 1);

    // program 2: wrap-around and undefined opcode
    clear_prog();
    prog[0] = 8'h08; prog[1] = 8'h19; prog[2] = 8'h30; prog[3] = 8'h2A;
    prog[4] = 8'h5A; prog[5] = 8'h30; prog[6] = 8'hF0;
    prog[8] = 8'hFF; prog[9] = 8'h02; prog[10] = 8'h03;
    start_prog();
    step(15);
    chk("R7 out before first OUT", out_o, 0);
    step(1);
    chk("R5 add wraps", out_o, 8'h01);
    step(60);
    chk("R6 R9 sub wraps, nop inert", out_o, 8'hFE);
    chk("R8 halted p2", halted_o, 1);

    // program 3: halt first
    clear_prog();
    prog[0] = 8'hF0; prog[1] = 8'h0F; prog[2] = 8'h30; prog[15] = 8'h77;
    start_prog();
    step(3);
    chk("R3 not halted before step 4", halted_o, 0);
    step(1);
    chk("R8 halted at step 4", halted_o, 1);
    step(40);
    chk("R8 frozen out", out_o, 0);

    // program 4: operand at top address
    clear_prog();
    prog[0] = 8'h0F; prog[1] = 8'h30; prog[2] = 8'hF0; prog[15] = 8'hA5;
    start_prog();
    step(9);
    chk("R3 out before edge 10", out_o, 0);
    step(1);
    chk("R1 R4 load from addr 15", out_o, 8'hA5);
    step(20);
    chk("R8 halted p4", halted_o, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule